// File: doc/BRIEF.md
# Serial ADC Frame Word Aligner

This block sits behind the deserializer of a serial LVDS converter link and rebuilds 12-bit samples from 6-bit parallel chunks. It runs in the chunk clock domain, which ticks twice per converter sample. Two lanes enter: the converted data and the converter's frame clock. The frame clock is deserialized exactly like a data bit. A fixed split of the bit stream would land on the sample boundary in only one case out of twelve, and ordinary sample data carries no marker. For that reason the boundary has to come from an explicit reference.

Two references are offered. In frame mode the block searches the frame lane for its high-then-low shape and freezes the shift where that shape sits. In pattern mode, intended for a calibration step after power-up, the converter sends a known sync word. The block steps through the twelve possible shifts until the data matches that word. After lock, one aligned word leaves the block on every second chunk cycle with a valid strobe. A resync input restarts the search.

Top module: `adc_frame_aligner`

## Requirements
- R1: A synchronous active-high `rst` clears the history, the shift, `locked`, `word_valid`, `frame_err` and `word_out`. All four outputs read zero during reset.
- R2: In each chunk, bit 5 is the earliest serial bit. Samples are sent MSB first. The block keeps a 24-bit history of each lane, and the selected word is the 12-bit slice at shift 0 to 11, with its MSB being the oldest bit.
- R3: In frame mode (`pattern_mode` = 0), the block locks on the shift at which the frame-lane slice reads six ones followed by six zeros (12'hFC0). After lock, `word_out` carries consecutive aligned samples, for every one of the 12 possible bit skews.
- R4: `locked` rises only after the same shift has been accepted on 4 consecutive sample evaluations. Evaluations happen every second chunk cycle, and only once the history is full.
- R5: `word_valid` pulses on every second chunk cycle while locked. It is never high on two adjacent cycles and never high while `locked` is low.
- R6: In frame mode, `frame_err` is raised and `locked` is dropped when no shift shows the frame shape, or when the frozen shift no longer shows it. Once the frame lane is clean again, the block relocks.
- R7: In pattern mode (`pattern_mode` = 1), the shifts are tried in turn starting from 0, moving on after each mismatch. The block locks on the first shift whose data slice equals `sync_word` on 4 consecutive evaluations. The first word output after lock equals `sync_word`.
- R8: While locked, the shift stays frozen. In pattern mode, data that no longer matches the sync word keeps the lock, and the words stay aligned.
- R9: `resync` clears the lock, the count and `frame_err` at the next clock edge and restarts the search from shift 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chunk clock, twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| data_chunk | input | 6 | Deserialized data bits, bit 5 earliest |
| frame_chunk | input | 6 | Deserialized frame-clock bits, bit 5 earliest |
| pattern_mode | input | 1 | 0: align on frame lane, 1: align on sync word |
| sync_word | input | 12 | Expected sync word in pattern mode |
| resync | input | 1 | Drop lock and restart the search |
| word_out | output | 12 | Aligned sample |
| word_valid | output | 1 | Strobe for `word_out` |
| locked | output | 1 | Alignment found and frozen |
| frame_err | output | 1 | Frame shape missing in frame mode |

## Verification
A chunk is registered into the history at one edge and evaluated at a later edge. The aligned word and its strobe are therefore registered two edges after the chunk that completes the word. `locked` and `frame_err` change at the same edge as the evaluation that decides them, and `resync` takes effect at the very next edge. The bench drives each chunk just after a falling edge and samples every output at the following falling edge. Because of this, each result is read one half-period after the edge that produced it. Alignment is checked arithmetically: the data lane carries a ramp whose consecutive samples differ by 37 modulo 4096, so every valid word must exceed its predecessor by exactly that step. Lock latency is bounded from below by the fill and count rules.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;

    typedef enum logic {
        ALIGN_FRAME   = 1'b0,
        ALIGN_PATTERN = 1'b1
    } align_mode_e;

    localparam int DEF_CHUNK_W = 6;
    localparam int DEF_LOCK_N  = 4;

endpackage

// File: rtl/adc_lane_history.sv
module adc_lane_history #(
    parameter int CHUNK_W = 6,
    parameter int HIST_W  = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CHUNK_W-1:0] chunk_in,
    output logic [HIST_W-1:0]  hist
);
    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = {hist_q[HIST_W-CHUNK_W-1:0], chunk_in};
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end

    assign hist = hist_q;

    // newest chunk lands at the low end, older bits move up
    assert_hist_load_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> hist_q[CHUNK_W-1:0] == $past(chunk_in));
endmodule

// File: rtl/adc_slice_mux.sv
module adc_slice_mux #(
    parameter int HIST_W = 24,
    parameter int WORD_W = 12,
    parameter int OFF_W  = 4
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [OFF_W-1:0]  off,
    output logic [WORD_W-1:0] slice
);
    always_comb begin
        slice = hist[off +: WORD_W];
    end
endmodule

// File: rtl/adc_frame_finder.sv
module adc_frame_finder #(
    parameter int HIST_W = 24,
    parameter int WORD_W = 12,
    parameter int OFF_W  = 4
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [WORD_W-1:0] shape,
    output logic              found,
    output logic [OFF_W-1:0]  found_off
);
    // lowest matching shift wins
    always_comb begin
        found     = 1'b0;
        found_off = '0;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (hist[k +: WORD_W] == shape) begin
                found     = 1'b1;
                found_off = OFF_W'(k);
            end
        end
    end
endmodule

// File: rtl/adc_frame_aligner.sv
module adc_frame_aligner #(
    parameter int CHUNK_W = adc_align_pkg::DEF_CHUNK_W,
    parameter int LOCK_N  = adc_align_pkg::DEF_LOCK_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CHUNK_W-1:0]   data_chunk,
    input  logic [CHUNK_W-1:0]   frame_chunk,
    input  logic                 pattern_mode,
    input  logic [2*CHUNK_W-1:0] sync_word,
    input  logic                 resync,
    output logic [2*CHUNK_W-1:0] word_out,
    output logic                 word_valid,
    output logic                 locked,
    output logic                 frame_err
);
    import adc_align_pkg::*;

    localparam int WORD_W = 2 * CHUNK_W;
    localparam int HIST_W = 2 * WORD_W;
    localparam int OFF_W  = $clog2(WORD_W);
    localparam int FILL_N = HIST_W / CHUNK_W;
    localparam int FILL_W = $clog2(FILL_N + 1);
    localparam int CNT_W  = $clog2(LOCK_N + 1);
    localparam logic [WORD_W-1:0] FRAME_SHAPE = {{CHUNK_W{1'b1}}, {CHUNK_W{1'b0}}};

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [CNT_W-1:0]  cnt;
        logic              locked;
        logic              err;
        logic              phase;
        logic [FILL_W-1:0] fill;
        logic [WORD_W-1:0] word;
        logic              valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [HIST_W-1:0] data_hist, frame_hist;
    logic [WORD_W-1:0] data_slice, frame_slice;
    logic              shape_found;
    logic [OFF_W-1:0]  shape_off;
    logic              eval;
    logic [CNT_W-1:0]  cnt_inc;
    align_mode_e       mode;

    adc_lane_history #(.CHUNK_W(CHUNK_W), .HIST_W(HIST_W)) u_data_hist (
        .clk(clk), .rst(rst), .chunk_in(data_chunk), .hist(data_hist));
    adc_lane_history #(.CHUNK_W(CHUNK_W), .HIST_W(HIST_W)) u_frame_hist (
        .clk(clk), .rst(rst), .chunk_in(frame_chunk), .hist(frame_hist));

    adc_slice_mux #(.HIST_W(HIST_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_data_mux (
        .hist(data_hist), .off(ctl_q.off), .slice(data_slice));
    adc_slice_mux #(.HIST_W(HIST_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_frame_mux (
        .hist(frame_hist), .off(ctl_q.off), .slice(frame_slice));

    adc_frame_finder #(.HIST_W(HIST_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_finder (
        .hist(frame_hist), .shape(FRAME_SHAPE), .found(shape_found), .found_off(shape_off));

    always_comb begin
        mode    = align_mode_e'(pattern_mode);
        eval    = ctl_q.phase && (ctl_q.fill == FILL_W'(FILL_N));
        cnt_inc = ctl_q.cnt + CNT_W'(1);
        ctl_d       = ctl_q;
        ctl_d.phase = ~ctl_q.phase;
        ctl_d.valid = 1'b0;
        if (ctl_q.fill != FILL_W'(FILL_N)) ctl_d.fill = ctl_q.fill + FILL_W'(1);

        if (resync) begin
            ctl_d.locked = 1'b0;
            ctl_d.cnt    = '0;
            ctl_d.off    = '0;
            ctl_d.err    = 1'b0;
        end else if (eval) begin
            if (mode == ALIGN_FRAME) begin
                if (ctl_q.locked) begin
                    if (frame_slice != FRAME_SHAPE) begin
                        ctl_d.err    = 1'b1;
                        ctl_d.locked = 1'b0;
                        ctl_d.cnt    = '0;
                    end else begin
                        ctl_d.err   = 1'b0;
                        ctl_d.valid = 1'b1;
                        ctl_d.word  = data_slice;
                    end
                end else if (!shape_found) begin
                    ctl_d.err = 1'b1;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.err = 1'b0;
                    if (shape_off == ctl_q.off && ctl_q.cnt != '0) begin
                        ctl_d.cnt = cnt_inc;
                        if (cnt_inc == CNT_W'(LOCK_N)) begin
                            ctl_d.locked = 1'b1;
                            ctl_d.cnt    = '0;
                        end
                    end else begin
                        ctl_d.off = shape_off;
                        ctl_d.cnt = CNT_W'(1);
                        if (LOCK_N == 1) begin
                            ctl_d.locked = 1'b1;
                            ctl_d.cnt    = '0;
                        end
                    end
                end
            end else begin
                ctl_d.err = 1'b0;
                if (ctl_q.locked) begin
                    ctl_d.valid = 1'b1;
                    ctl_d.word  = data_slice;
                end else if (data_slice == sync_word) begin
                    ctl_d.cnt = cnt_inc;
                    if (cnt_inc == CNT_W'(LOCK_N)) begin
                        ctl_d.locked = 1'b1;
                        ctl_d.cnt    = '0;
                    end
                end else begin
                    ctl_d.cnt = '0;
                    ctl_d.off = (ctl_q.off == OFF_W'(WORD_W - 1)) ? '0 : ctl_q.off + OFF_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign word_out   = ctl_q.word;
    assign word_valid = ctl_q.valid;
    assign locked     = ctl_q.locked;
    assign frame_err  = ctl_q.err;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!locked && !word_valid && !frame_err));
    assert_off_range_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_q.off < OFF_W'(WORD_W));
    assert_lock_after_count_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (LOCK_N == 1 || $past(ctl_q.cnt) == CNT_W'(LOCK_N - 1)));
    assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> locked);
    assert_valid_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
    assert_err_unlocks_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> !locked);
    assert_off_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        locked |=> (!locked || $stable(ctl_q.off)));
    assert_resync_drop_R9: assert property (@(posedge clk) disable iff (rst)
        resync |=> (!locked && !frame_err));
endmodule

// File: tb/adc_frame_aligner_tb.sv
module adc_frame_aligner_tb;
    localparam logic [11:0] SYNC = 12'h801;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  data_chunk, frame_chunk;
    logic        pattern_mode;
    logic [11:0] sync_word;
    logic        resync;
    logic [11:0] word_out;
    logic        word_valid, locked, frame_err;

    always #5 clk = ~clk;

    adc_frame_aligner u_dut (
        .clk(clk), .rst(rst), .data_chunk(data_chunk), .frame_chunk(frame_chunk),
        .pattern_mode(pattern_mode), .sync_word(sync_word), .resync(resync),
        .word_out(word_out), .word_valid(word_valid), .locked(locked), .frame_err(frame_err));

    int     checks = 0;
    int     errors = 0;
    int     skew = 0;
    longint tbit = 120;
    int     ramp_from = 0;
    bit     frame_bad = 0;
    bit     ramp_chk = 0;
    bit     have_prev = 0;
    bit     prev_valid = 0;
    bit     err_seen = 0;
    logic [11:0] prev_word = '0;

    function automatic logic [11:0] sample_val(int n);
        if (n < ramp_from) return SYNC;
        return 12'((n * 37 + 100) % 4096);
    endfunction

    function automatic logic data_bit(longint t);
        int r = int'(t) - skew;
        logic [11:0] w = sample_val(r / 12);
        return w[11 - (r % 12)];
    endfunction

    function automatic logic frame_bit(longint t);
        int r = int'(t) - skew;
        if (frame_bad) return 1'b1;
        return (r % 12) < 6;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // sample outputs at the falling edge, then drive the next chunk
    task automatic step();
        @(negedge clk);
        if (frame_err) err_seen = 1;
        if (word_valid) begin
            check(locked, "R5 valid while locked", int'(locked), 1);
            check(!prev_valid, "R5 valid spacing", int'(prev_valid), 0);
            if (ramp_chk) begin
                if (have_prev)
                    check(word_out == 12'(prev_word + 12'd37), "R2/R3 ramp step",
                          int'(word_out), int'(12'(prev_word + 12'd37)));
                prev_word = word_out;
                have_prev = 1;
            end
        end
        prev_valid = word_valid;
        for (int i = 0; i < 6; i++) begin
            data_chunk[5-i]  = data_bit(tbit + i);
            frame_chunk[5-i] = frame_bit(tbit + i);
        end
        tbit += 6;
    endtask

    task automatic do_reset();
        rst = 1;
        resync = 0;
        step();
        step();
        step();
        check(!locked && !word_valid && !frame_err && word_out == 12'h0, "R1 reset state",
              int'({locked, word_valid, frame_err, word_out}), 0);
        rst = 0;
    endtask

    task automatic wait_lock(input int maxc, output int used);
        used = 0;
        while (!locked && used < maxc) begin
            step();
            used++;
        end
    endtask

    task automatic ramp_run(input int n);
        ramp_chk = 1;
        have_prev = 0;
        for (int i = 0; i < n; i++) step();
        ramp_chk = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int used;
        rst = 1; resync = 0; pattern_mode = 0; sync_word = SYNC;
        data_chunk = '0; frame_chunk = '0;

        // frame mode, every skew
        for (int s = 0; s < 12; s++) begin
            skew = s; ramp_from = 0; pattern_mode = 0; frame_bad = 0;
            do_reset();
            err_seen = 0;
            wait_lock(60, used);
            check(locked, "R3 frame lock", int'(locked), 1);
            check(used >= 8, "R4 lock not early", used, 8);
            ramp_run(24);
            check(!err_seen, "R6 no false error", int'(err_seen), 0);
        end

        // frame error and relock
        skew = 5; frame_bad = 1; err_seen = 0;
        for (int i = 0; i < 8; i++) step();
        check(err_seen, "R6 error raised", int'(err_seen), 1);
        check(!locked, "R6 lock dropped", int'(locked), 0);
        frame_bad = 0;
        wait_lock(60, used);
        check(locked, "R6 relock", int'(locked), 1);
        ramp_run(16);

        // pattern mode, every skew
        for (int s = 0; s < 12; s++) begin
            skew = s; ramp_from = 1 << 30; pattern_mode = 1;
            do_reset();
            wait_lock(100, used);
            check(locked, "R7 pattern lock", int'(locked), 1);
            check(used >= 8, "R4 pattern lock not early", used, 8);
            used = 0;
            while (!word_valid && used < 4) begin step(); used++; end
            check(word_valid && word_out == SYNC, "R7 sync word out", int'(word_out), int'(SYNC));
            ramp_from = (int'(tbit) - skew) / 12 + 2;
            for (int i = 0; i < 10; i++) step();
            ramp_run(24);
            check(locked, "R8 lock held on new data", int'(locked), 1);
        end

        // resync
        resync = 1;
        step();
        resync = 0;
        check(!locked, "R9 resync drops lock", int'(locked), 0);
        for (int i = 0; i < 40; i++) step();
        check(!locked, "R9 no relock on ramp", int'(locked), 0);
        ramp_from = 1 << 30;
        wait_lock(100, used);
        check(locked, "R9 search restarted", int'(locked), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule